// File: doc/BRIEF.md
# Debug Port Posted-Read Access Logic

This block sits between a serial debug link's packet decoder and a memory-mapped access port. Each decoded request carries a port-select flag, a direction bit, a two-bit register address and write data. A request with the port-select flag clear goes to one of four local debug-port registers. A request with the flag set goes to an access-port register. The block forms that register's word address and issues it on a simple valid/ready bus request channel.

The block holds a window register. One field of it names the active access port. A four-bit bank field of it picks one four-word window out of the 64-word access-port register space. Access-port reads are posted. A read returns at once the value captured by the previous access-port read, and it launches a new bus read. When that read completes, its data lands in a capture register. The next access-port read returns the captured value. So does the last-read register on the debug side, which does not start a bus transaction. While a bus transaction is outstanding, the block answers any further request that needs the access-port path with a busy (WAIT-style) response. It does not queue such a request.

Top module: `dbg_post_acc`

## Requirements
- R1: After reset, `ap_sel` and the capture register are zero, and `rsp_valid` and `bus_req_valid` are low. A last-read request issued right after reset returns 0.
- R2: A debug-port write to address 2'b10 loads the window register. Write data bits [31:24] appear on `ap_sel`, and bits [7:4] become the bank used for access-port addresses.
- R3: A launched access-port transaction drives `bus_req_addr` with the bank field in bits [5:2] and the request address in bits [1:0].
- R4: An access-port read accepted while idle returns the capture register's value in the following cycle. In that same cycle it raises `bus_req_valid` with `bus_req_write` low.
- R5: When `bus_rsp_valid` completes an outstanding read, its data is stored in the capture register. The next access-port read returns that data.
- R6: A debug-port read of address 2'b11 returns the capture register's value and launches no bus transaction.
- R7: An access-port request or a last-read request that arrives while a bus transaction is outstanding gets `rsp_busy` high and `rsp_data` zero. It launches nothing and leaves the capture register unchanged.
- R8: An access-port write drives the bus with `bus_req_write` high, the formed address and the request's write data. Its completion leaves the capture register unchanged.
- R9: Once raised, `bus_req_valid` stays high, and the address, write flag and data stay stable, until a cycle in which `bus_req_ready` is high.
- R10: Debug-port reads return the parameter `ID_VALUE` at address 2'b00, the outstanding flag in bit 0 at address 2'b01, and zero at address 2'b10 (write-only). Debug-port writes to addresses 2'b00, 2'b01 and 2'b11 have no effect.
- R11: Every cycle with `req_valid` high is answered by exactly one `rsp_valid` pulse in the next cycle. A cycle without a request gives no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Decoded request present this cycle |
| req_is_ap | input | 1 | 1 = access-port register, 0 = debug-port register |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_addr | input | 2 | Register address bits from the request |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_busy | output | 1 | WAIT-style answer: request not performed |
| rsp_data | output | 32 | Read data of the response |
| ap_sel | output | 8 | Currently selected access port |
| bus_req_valid | output | 1 | Bus request valid |
| bus_req_ready | input | 1 | Bus accepts request |
| bus_req_addr | output | 6 | Access-port register word address |
| bus_req_write | output | 1 | 1 = bus write |
| bus_req_wdata | output | 32 | Bus write data |
| bus_rsp_valid | input | 1 | Bus transaction complete |
| bus_rsp_rdata | input | 32 | Bus read data |

## Verification
Every response and every bus launch is registered. The response fields, `bus_req_valid` and the bus address are due in the first cycle after the clock edge that samples the request. The bench drives inputs on the falling edge and checks these outputs on the next falling edge, one edge after acceptance. A capture update takes effect on the edge that samples `bus_rsp_valid`, so the bench reads it back with a later last-read or access-port request rather than in the same cycle. The busy cases hold `bus_req_ready` low for several cycles, so that the held-request and WAIT behaviour can be seen over more than one edge.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

  // Debug-port register addresses (request address bits)
  localparam logic [1:0] DPA_ID     = 2'b00;
  localparam logic [1:0] DPA_STAT   = 2'b01;
  localparam logic [1:0] DPA_WIN    = 2'b10;
  localparam logic [1:0] DPA_LASTRD = 2'b11;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_REQ  = 2'd1,
    BUS_WAIT = 2'd2
  } bus_st_t;

endpackage

// File: rtl/dpa_win_reg.sv
module dpa_win_reg #(
  parameter int DATA_W   = 32,
  parameter int PORT_W   = 8,
  parameter int PORT_LSB = 24,
  parameter int BANK_W   = 4,
  parameter int BANK_LSB = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [PORT_W-1:0] port_q,
  output logic [BANK_W-1:0] bank_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      port_q <= '0;
      bank_q <= '0;
    end else if (wr_en) begin
      port_q <= wdata[PORT_LSB +: PORT_W];
      bank_q <= wdata[BANK_LSB +: BANK_W];
    end
  end

endmodule

// File: rtl/dpa_capture.sv
module dpa_capture #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= din;
  end

endmodule

// File: rtl/dpa_bus_ctrl.sv
module dpa_bus_ctrl
  import dpa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  // launch from request decode
  input  logic              launch,
  input  logic              launch_write,
  input  logic [ADDR_W-1:0] launch_addr,
  input  logic [DATA_W-1:0] launch_wdata,
  output logic              busy,
  // bus side
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic              bus_req_write,
  output logic [DATA_W-1:0] bus_req_wdata,
  input  logic              bus_rsp_valid,
  // read completion
  output logic              rd_done
);

  bus_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      BUS_IDLE: if (launch)        st_d = BUS_REQ;
      BUS_REQ:  if (bus_req_ready) st_d = BUS_WAIT;
      BUS_WAIT: if (bus_rsp_valid) st_d = BUS_IDLE;
      default:                     st_d = BUS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= BUS_IDLE;
      bus_req_addr  <= '0;
      bus_req_write <= 1'b0;
      bus_req_wdata <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == BUS_IDLE && launch) begin
        bus_req_addr  <= launch_addr;
        bus_req_write <= launch_write;
        bus_req_wdata <= launch_wdata;
      end
    end
  end

  assign busy          = (st_q != BUS_IDLE);
  assign bus_req_valid = (st_q == BUS_REQ);
  assign rd_done       = (st_q == BUS_WAIT) && bus_rsp_valid && !bus_req_write;

endmodule

// File: rtl/dbg_post_acc.sv
module dbg_post_acc
  import dpa_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          PORT_W   = 8,
  parameter int          BANK_W   = 4,
  parameter int          REQ_A_W  = 2,
  parameter logic [31:0] ID_VALUE = 32'h1BA0_1477
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic                        req_is_ap,
  input  logic                        req_rnw,
  input  logic [REQ_A_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]           req_wdata,
  output logic                        rsp_valid,
  output logic                        rsp_busy,
  output logic [DATA_W-1:0]           rsp_data,
  output logic [PORT_W-1:0]           ap_sel,
  output logic                        bus_req_valid,
  input  logic                        bus_req_ready,
  output logic [BANK_W+REQ_A_W-1:0]   bus_req_addr,
  output logic                        bus_req_write,
  output logic [DATA_W-1:0]           bus_req_wdata,
  input  logic                        bus_rsp_valid,
  input  logic [DATA_W-1:0]           bus_rsp_rdata
);

  localparam int ADDR_W   = BANK_W + REQ_A_W;
  localparam int PORT_LSB = DATA_W - PORT_W;
  localparam int BANK_LSB = 4;

  logic [BANK_W-1:0] win_bank;
  logic [DATA_W-1:0] cap_q;
  logic              bus_busy;
  logic              rd_done;

  // request classification
  logic is_lastrd, needs_ap_path, stall, launch, win_wr;
  logic [DATA_W-1:0] rsp_d;

  assign is_lastrd     = !req_is_ap && req_rnw && (req_addr == DPA_LASTRD);
  assign needs_ap_path = req_is_ap || is_lastrd;
  assign stall         = needs_ap_path && bus_busy;
  assign launch        = req_valid && req_is_ap && !bus_busy;
  assign win_wr        = req_valid && !req_is_ap && !req_rnw && (req_addr == DPA_WIN);

  dpa_win_reg #(
    .DATA_W  (DATA_W),
    .PORT_W  (PORT_W),
    .PORT_LSB(PORT_LSB),
    .BANK_W  (BANK_W),
    .BANK_LSB(BANK_LSB)
  ) u_win (
    .clk   (clk),
    .rst   (rst),
    .wr_en (win_wr),
    .wdata (req_wdata),
    .port_q(ap_sel),
    .bank_q(win_bank)
  );

  dpa_bus_ctrl #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_bus (
    .clk          (clk),
    .rst          (rst),
    .launch       (launch),
    .launch_write (!req_rnw),
    .launch_addr  ({win_bank, req_addr}),
    .launch_wdata (req_wdata),
    .busy         (bus_busy),
    .bus_req_valid(bus_req_valid),
    .bus_req_ready(bus_req_ready),
    .bus_req_addr (bus_req_addr),
    .bus_req_write(bus_req_write),
    .bus_req_wdata(bus_req_wdata),
    .bus_rsp_valid(bus_rsp_valid),
    .rd_done      (rd_done)
  );

  dpa_capture #(
    .DATA_W(DATA_W)
  ) u_cap (
    .clk (clk),
    .rst (rst),
    .load(rd_done),
    .din (bus_rsp_rdata),
    .q   (cap_q)
  );

  // response data selection
  always_comb begin
    rsp_d = '0;
    if (stall) begin
      rsp_d = '0;
    end else if (req_is_ap) begin
      if (req_rnw) rsp_d = cap_q;
    end else if (req_rnw) begin
      unique case (req_addr)
        DPA_ID:     rsp_d = ID_VALUE[DATA_W-1:0];
        DPA_STAT:   rsp_d = {{(DATA_W-1){1'b0}}, bus_busy};
        DPA_WIN:    rsp_d = '0;
        DPA_LASTRD: rsp_d = cap_q;
        default:    rsp_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_busy  <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_busy  <= req_valid && stall;
      rsp_data  <= req_valid ? rsp_d : '0;
    end
  end

endmodule

// File: rtl/dbg_post_acc_chk.sv
module dbg_post_acc_chk #(
  parameter int DATA_W  = 32,
  parameter int BANK_W  = 4,
  parameter int REQ_A_W = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      req_valid,
  input logic                      req_is_ap,
  input logic                      req_rnw,
  input logic [REQ_A_W-1:0]        req_addr,
  input logic                      rsp_valid,
  input logic                      rsp_busy,
  input logic [DATA_W-1:0]         rsp_data,
  input logic                      bus_req_valid,
  input logic                      bus_req_ready,
  input logic [BANK_W+REQ_A_W-1:0] bus_req_addr,
  input logic                      bus_req_write,
  input logic [DATA_W-1:0]         bus_req_wdata,
  input logic [BANK_W-1:0]         win_bank,
  input logic [DATA_W-1:0]         cap_q,
  input logic                      bus_busy
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rsp_valid && !bus_req_valid && cap_q == '0));

  // R11
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R11
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R4
  posted_read_data_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_is_ap && req_rnw && !bus_busy)
      |=> (rsp_data == $past(cap_q) && bus_req_valid && !bus_req_write));

  // R3
  addr_form_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_is_ap && !bus_busy)
      |=> (bus_req_addr == {$past(win_bank), $past(req_addr)}));

  // R6
  lastrd_no_launch_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_is_ap && req_rnw && req_addr == 2'b11 && !bus_req_valid)
      |=> !bus_req_valid);

  // R7
  busy_no_launch_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_busy) |-> (!$rose(bus_req_valid) && rsp_data == '0));

  // R8
  write_keeps_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_is_ap && !req_rnw && !bus_busy) |=> $stable(cap_q));

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req_valid && !bus_req_ready)
      |=> (bus_req_valid && $stable(bus_req_addr) && $stable(bus_req_write)
           && $stable(bus_req_wdata)));

endmodule

bind dbg_post_acc dbg_post_acc_chk #(
  .DATA_W (DATA_W),
  .BANK_W (BANK_W),
  .REQ_A_W(REQ_A_W)
) u_chk (.*);

// File: tb/dbg_post_acc_tb.sv
module dbg_post_acc_tb;

  localparam logic [31:0] ID_V = 32'h1BA0_1477;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_is_ap = 1'b0, req_rnw = 1'b0;
  logic [1:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_busy;
  logic [31:0] rsp_data;
  logic [7:0]  ap_sel;
  logic        bus_req_valid;
  logic        bus_req_ready = 1'b1;
  logic [5:0]  bus_req_addr;
  logic        bus_req_write;
  logic [31:0] bus_req_wdata;
  logic        bus_rsp_valid = 1'b0;
  logic [31:0] bus_rsp_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  dbg_post_acc #(.ID_VALUE(ID_V)) u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_is_ap(req_is_ap), .req_rnw(req_rnw),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_busy(rsp_busy), .rsp_data(rsp_data),
    .ap_sel(ap_sel),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_req_addr(bus_req_addr), .bus_req_write(bus_req_write),
    .bus_req_wdata(bus_req_wdata),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_rdata(bus_rsp_rdata)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one request on a falling edge; return on the falling edge after it
  // was sampled, when the registered response is visible.
  task automatic do_req(input bit ap, input bit rnw, input logic [1:0] a,
                        input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_is_ap = ap; req_rnw = rnw; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Complete the outstanding bus transaction (request already accepted).
  task automatic bus_done(input logic [31:0] d);
    @(negedge clk);
    bus_rsp_valid = 1'b1; bus_rsp_rdata = d;
    @(negedge clk);
    bus_rsp_valid = 1'b0;
  endtask

  task automatic t_reset;
    check(!rsp_valid, "R1 rsp_valid", {31'b0, rsp_valid}, 0);
    check(!bus_req_valid, "R1 bus_req_valid", {31'b0, bus_req_valid}, 0);
    check(ap_sel == 8'h00, "R1 ap_sel", {24'b0, ap_sel}, 0);
    do_req(1'b0, 1'b1, 2'b11, '0);
    check(rsp_valid && !rsp_busy && rsp_data == 0, "R1 capture zero", rsp_data, 0);
    check(!bus_req_valid, "R6 no launch", {31'b0, bus_req_valid}, 0);
  endtask

  task automatic t_window;
    do_req(1'b0, 1'b0, 2'b10, 32'h5A00_0030);
    check(ap_sel == 8'h5A, "R2 ap_sel", {24'b0, ap_sel}, 32'h5A);
    do_req(1'b0, 1'b1, 2'b10, '0);
    check(rsp_data == 0, "R10 window read zero", rsp_data, 0);
    do_req(1'b0, 1'b1, 2'b00, '0);
    check(rsp_data == ID_V, "R10 id read", rsp_data, ID_V);
    @(negedge clk);
    check(!rsp_valid, "R11 idle no rsp", {31'b0, rsp_valid}, 0);
  endtask

  task automatic t_posted;
    do_req(1'b1, 1'b1, 2'b01, '0);
    check(rsp_valid && !rsp_busy && rsp_data == 0, "R4 posted first", rsp_data, 0);
    check(bus_req_valid && !bus_req_write, "R4 launch read",
          {30'b0, bus_req_valid, bus_req_write}, 32'h2);
    check(bus_req_addr == 6'h0D, "R3 addr", {26'b0, bus_req_addr}, 32'h0D);
    do_req(1'b0, 1'b1, 2'b01, '0);
    check(rsp_data == 1, "R10 status busy", rsp_data, 1);
    bus_done(32'hCAFE_0001);
    do_req(1'b0, 1'b1, 2'b11, '0);
    check(rsp_data == 32'hCAFE_0001 && !rsp_busy, "R6 last read", rsp_data, 32'hCAFE_0001);
    check(!bus_req_valid, "R6 no launch", {31'b0, bus_req_valid}, 0);
    do_req(1'b1, 1'b1, 2'b10, '0);
    check(rsp_data == 32'hCAFE_0001, "R5 previous data", rsp_data, 32'hCAFE_0001);
    check(bus_req_addr == 6'h0E, "R3 addr", {26'b0, bus_req_addr}, 32'h0E);
    bus_done(32'h1234_5678);
  endtask

  task automatic t_busy;
    do_req(1'b0, 1'b0, 2'b10, 32'h0100_00F0);
    bus_req_ready = 1'b0;
    do_req(1'b1, 1'b1, 2'b00, '0);
    check(rsp_data == 32'h1234_5678, "R5 posted data", rsp_data, 32'h1234_5678);
    check(bus_req_addr == 6'h3C, "R3 addr bank F", {26'b0, bus_req_addr}, 32'h3C);
    do_req(1'b1, 1'b1, 2'b11, '0);
    check(rsp_busy && rsp_data == 0, "R7 ap busy", rsp_data, 0);
    check(bus_req_valid && bus_req_addr == 6'h3C, "R9 held",
          {26'b0, bus_req_addr}, 32'h3C);
    do_req(1'b0, 1'b1, 2'b11, '0);
    check(rsp_busy, "R7 last read busy", {31'b0, rsp_busy}, 1);
    @(negedge clk);
    check(bus_req_valid && bus_req_addr == 6'h3C, "R9 still held",
          {26'b0, bus_req_addr}, 32'h3C);
    bus_req_ready = 1'b1;
    bus_done(32'h0000_AAAA);
    do_req(1'b0, 1'b1, 2'b11, '0);
    check(rsp_data == 32'h0000_AAAA && !rsp_busy, "R5 capture after busy",
          rsp_data, 32'h0000_AAAA);
  endtask

  task automatic t_write;
    do_req(1'b1, 1'b0, 2'b11, 32'hDEAD_BEEF);
    check(bus_req_valid && bus_req_write, "R8 write flag", {31'b0, bus_req_write}, 1);
    check(bus_req_addr == 6'h3F, "R8 write addr", {26'b0, bus_req_addr}, 32'h3F);
    check(bus_req_wdata == 32'hDEAD_BEEF, "R8 write data", bus_req_wdata, 32'hDEAD_BEEF);
    bus_done(32'hFFFF_FFFF);
    do_req(1'b0, 1'b1, 2'b11, '0);
    check(rsp_data == 32'h0000_AAAA, "R8 capture kept", rsp_data, 32'h0000_AAAA);
  endtask

  task automatic t_ignored;
    do_req(1'b0, 1'b0, 2'b11, 32'h7777_7777);
    do_req(1'b0, 1'b0, 2'b00, 32'h9900_0000);
    do_req(1'b0, 1'b0, 2'b01, 32'h8800_0000);
    check(ap_sel == 8'h01, "R10 writes ignored sel", {24'b0, ap_sel}, 1);
    do_req(1'b0, 1'b1, 2'b11, '0);
    check(rsp_data == 32'h0000_AAAA, "R10 writes ignored cap", rsp_data, 32'h0000_AAAA);
    check(!bus_req_valid, "R10 no launch", {31'b0, bus_req_valid}, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_window();
    t_posted();
    t_busy();
    t_write();
    t_ignored();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule